// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns every access on a 32-bit address bus into an encoded chip-select number. It has four channels. Each channel holds a base word and a mask word, and software loads them through a one-cycle register write port. For each access, every channel compares the upper 24 address bits and the 3-bit processor function code against its base word. Mask bits set to 1 are treated as "don't care". The lowest-numbered channel that is enabled and matches wins, and the block reports that channel's index plus one. When no channel matches, the result is 0.

After reset all storage is clear, and the block starts in a boot mode. In boot mode every access decodes to select 1, so a boot memory is reachable before any programming. A two-state machine follows the enable bit of channel 0:

- MODE_BOOT is the reset state.
- The ENABLE transition, to MODE_MAPPED, happens when channel 0's base word is written with bit 0 set.
- The DISABLE transition, back to MODE_BOOT, happens when channel 0's base word is written with bit 0 clear.

The select number is produced combinationally. A registered copy is also provided, captured on an access-valid strobe.

Top module: `chip_select_decoder`

## Requirements
- R1: After reset all base and mask words are zero, the block is in MODE_BOOT, `cs_sel` is 1 for any access, and `cs_sel_q` and `cs_sel_q_vld` are 0.
- R2: While bit 0 of channel 0's base word is 0, `cs_sel` is 1 for every address and function code, whatever the other channels hold.
- R3: A channel whose base bit 0 is 0 never matches.
- R4: Address bits 7:0 are never compared. Bits 31:8 of the address must equal base bits 31:8 wherever the corresponding mask bit is 0.
- R5: The 4-bit word {1'b0, function code} must equal base bits 7:4 wherever mask bits 7:4 are 0. A set mask bit in that field makes the bit "don't care".
- R6: When several enabled channels match, `cs_sel` is the lowest matching index plus one (channel 0 → 1, channel 3 → 4).
- R7: When channel 0 is enabled and no enabled channel matches, `cs_sel` is 0.
- R8: A write with `wr_en` high stores `wr_data` in the word chosen by `wr_ch` (0..3) and `wr_is_mask` (0 = base, 1 = mask). The write affects decoding from the cycle after the clock edge, and the mode follows channel 0's bit 0.
- R9: On a clock edge with `acc_valid` high, `cs_sel_q` takes the current `cs_sel` and `cs_sel_q_vld` becomes 1. Without the strobe, `cs_sel_q` holds and `cs_sel_q_vld` is 0.
- R10: Bits 3:1 of both the base word and the mask word are stored but have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_ch | input | 2 | Channel index of the write |
| wr_is_mask | input | 1 | 0 writes the base word, 1 writes the mask word |
| wr_data | input | 32 | Write data |
| acc_addr | input | 32 | Access address |
| acc_fc | input | 3 | Access function code |
| acc_valid | input | 1 | Access strobe that captures the registered select |
| cs_sel | output | 3 | Combinational select number, 0..4 |
| cs_sel_q | output | 3 | Registered select number |
| cs_sel_q_vld | output | 1 | Registered select captured in the previous cycle |

## Verification
The following properties are checked on every cycle by assertions:
- Boot mode forces select 1.
- A disabled channel never reports a hit.
- The reported number belongs to the lowest hitting channel.
- An empty hit vector gives 0 once mapped.
- The registered copy follows the strobe and holds without it.
- The mode register agrees with channel 0's enable bit.

Only the bench scenarios can show that the address and function-code comparisons are correct. These cover:
- mask boundaries at the edges of each window
- ignored low address bits
- function-code mismatch falling through to a lower-priority channel
- the ignored bits 3:1
- leaving boot mode and returning to it

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int NUM_CH   = 4;
    localparam int ADDR_W   = 32;
    localparam int FC_W     = 3;
    localparam int IGN_LSBS = 8;    // address bits never compared
    localparam int FC_LSB   = 4;    // function-code field position in base/mask
    localparam int FC_FLD_W = 4;    // width of that field
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int SEL_W    = $clog2(NUM_CH + 1);

    typedef enum logic {
        MODE_BOOT   = 1'b0,
        MODE_MAPPED = 1'b1
    } cs_mode_e;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
    import cs_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [CH_W-1:0]                 wr_ch,
    input  logic                            wr_is_mask,
    input  logic [ADDR_W-1:0]               wr_data,
    output logic [NUM_CH-1:0][ADDR_W-1:0]   base_o,
    output logic [NUM_CH-1:0][ADDR_W-1:0]   mask_o,
    output logic                            boot_o
);
    logic [NUM_CH-1:0][ADDR_W-1:0] base_q;
    logic [NUM_CH-1:0][ADDR_W-1:0] mask_q;
    cs_mode_e mode_q, mode_d;

    logic ch0_base_wr;
    assign ch0_base_wr = wr_en && !wr_is_mask && (wr_ch == '0);

    // storage, one word pair per channel
    for (genvar i = 0; i < NUM_CH; i++) begin : g_store
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                mask_q[i] <= '0;
            end else if (wr_en && (wr_ch == CH_W'(i))) begin
                if (wr_is_mask) mask_q[i] <= wr_data;
                else            base_q[i] <= wr_data;
            end
        end
    end

    // mode state machine: ENABLE / DISABLE transitions on channel 0 base writes
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_BOOT:   if (ch0_base_wr &&  wr_data[0]) mode_d = MODE_MAPPED;
            MODE_MAPPED: if (ch0_base_wr && !wr_data[0]) mode_d = MODE_BOOT;
            default:     mode_d = MODE_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_BOOT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        base_o = base_q;
        mask_o = mask_q;
        boot_o = (mode_q == MODE_BOOT);
    end

    assert_mode_tracks_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_MAPPED) == base_q[0][0])
        else $error("mode register disagrees with channel 0 enable");
endmodule

// File: rtl/cs_channel_match.sv
module cs_channel_match
    import cs_pkg::*;
(
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [FC_W-1:0]   acc_fc,
    output logic              hit_o
);
    localparam int HI_W = ADDR_W - IGN_LSBS;

    logic [HI_W-1:0]     addr_diff;
    logic [FC_FLD_W-1:0] fc_word;
    logic [FC_FLD_W-1:0] fc_diff;
    logic                addr_ok;
    logic                fc_ok;
    logic                enabled;
    logic                unused_bits;

    always_comb begin
        addr_diff = (acc_addr[ADDR_W-1:IGN_LSBS] ^ base_i[ADDR_W-1:IGN_LSBS])
                  & ~mask_i[ADDR_W-1:IGN_LSBS];
        fc_word   = FC_FLD_W'(acc_fc);
        fc_diff   = (fc_word ^ base_i[FC_LSB +: FC_FLD_W]) & ~mask_i[FC_LSB +: FC_FLD_W];
        addr_ok   = (addr_diff == '0);
        fc_ok     = (fc_diff == '0);
        enabled   = base_i[0];
        hit_o     = enabled && addr_ok && fc_ok;
    end

    // bits kept in storage but outside the comparison
    assign unused_bits = ^{base_i[FC_LSB-1:1], mask_i[FC_LSB-1:0], acc_addr[IGN_LSBS-1:0]};
endmodule

// File: rtl/cs_prio_enc.sv
module cs_prio_enc
    import cs_pkg::*;
(
    input  logic [NUM_CH-1:0] hit_i,
    input  logic              boot_i,
    output logic [SEL_W-1:0]  sel_o
);
    always_comb begin
        sel_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit_i[i]) sel_o = SEL_W'(i + 1);
        end
        if (boot_i) sel_o = SEL_W'(1);
    end
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_ch,
    input  logic              wr_is_mask,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       acc_addr,
    input  logic [2:0]        acc_fc,
    input  logic              acc_valid,
    output logic [2:0]        cs_sel,
    output logic [2:0]        cs_sel_q,
    output logic              cs_sel_q_vld
);
    logic [NUM_CH-1:0][ADDR_W-1:0] base_w;
    logic [NUM_CH-1:0][ADDR_W-1:0] mask_w;
    logic                          boot_w;
    logic [NUM_CH-1:0]             hit_w;
    logic [SEL_W-1:0]              sel_w;
    logic [SEL_W-1:0]              sel_q;
    logic                          vld_q;

    cs_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_ch      (wr_ch),
        .wr_is_mask (wr_is_mask),
        .wr_data    (wr_data),
        .base_o     (base_w),
        .mask_o     (mask_w),
        .boot_o     (boot_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cs_channel_match u_match (
            .base_i   (base_w[i]),
            .mask_i   (mask_w[i]),
            .acc_addr (acc_addr),
            .acc_fc   (acc_fc),
            .hit_o    (hit_w[i])
        );

        assert_disabled_never_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !base_w[i][0] |-> !hit_w[i])
            else $error("disabled channel %0d reported a hit", i);

        assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!boot_w && hit_w[i] && ((hit_w & NUM_CH'((1 << i) - 1)) == '0))
            |-> (cs_sel == 3'(i + 1)))
            else $error("channel %0d is lowest hit but not selected", i);
    end

    cs_prio_enc u_enc (
        .hit_i  (hit_w),
        .boot_i (boot_w),
        .sel_o  (sel_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= acc_valid;
            if (acc_valid) sel_q <= sel_w;
        end
    end

    assign cs_sel       = sel_w;
    assign cs_sel_q     = sel_q;
    assign cs_sel_q_vld = vld_q;

    assert_boot_selects_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_w |-> (cs_sel == 3'd1))
        else $error("boot mode did not select 1");

    assert_no_hit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_w && hit_w == '0) |-> (cs_sel == 3'd0))
        else $error("no hit but nonzero select");

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (cs_sel_q_vld && cs_sel_q == $past(cs_sel)))
        else $error("registered select not captured");

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!cs_sel_q_vld && $stable(cs_sel_q)))
        else $error("registered select changed without strobe");
endmodule

// File: tb/tb_chip_select_decoder.sv
module tb_chip_select_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic        wr_is_mask = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_fc = '0;
    logic        acc_valid = 1'b0;
    logic [2:0]  cs_sel, cs_sel_q;
    logic        cs_sel_q_vld;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chip_select_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_is_mask(wr_is_mask), .wr_data(wr_data), .acc_addr(acc_addr),
        .acc_fc(acc_fc), .acc_valid(acc_valid), .cs_sel(cs_sel),
        .cs_sel_q(cs_sel_q), .cs_sel_q_vld(cs_sel_q_vld)
    );

    // {address, function code, expected select}
    // Map: ch0 0x000xxxxx any fc; ch1 0x0040xxxx any fc;
    //      ch2 0x0080xxxx fc==5 only; ch3 0x00xxxxxx any fc
    localparam logic [37:0] VEC [NV] = '{
        {32'h0001_2345, 3'd6, 3'd1},  // R6 ch0 beats ch3
        {32'h0040_1234, 3'd1, 3'd2},  // R4 ch1
        {32'h0080_1200, 3'd5, 3'd3},  // R5 fc match ch2
        {32'h0080_1200, 3'd4, 3'd4},  // R5 fc miss falls to ch3
        {32'h0123_0000, 3'd5, 3'd0},  // R7 nothing
        {32'hFFFF_FFFF, 3'd7, 3'd0},  // R7 nothing
        {32'h0000_00FF, 3'd0, 3'd1},  // R4 low bits ignored
        {32'h000F_FFFF, 3'd2, 3'd1},  // R4 top of ch0 window
        {32'h0010_0000, 3'd2, 3'd4},  // R4 just past ch0 window
        {32'h0040_FFFF, 3'd3, 3'd2},  // R4 top of ch1 window
        {32'h0041_0000, 3'd3, 3'd4},  // R4 just past ch1 window
        {32'h0080_0000, 3'd7, 3'd4}   // R5 fc 7 rejected by ch2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] ch, input logic is_mask, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch; wr_is_mask = is_mask; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [2:0] fc);
        @(negedge clk);
        acc_addr = a; acc_fc = fc;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        probe(32'h1234_5678, 3'd3);
        check("R1 sel after reset", cs_sel, 1);
        check("R1 sel_q after reset", cs_sel_q, 0);
        check("R1 vld after reset", cs_sel_q_vld, 0);
        rst_n = 1'b1;

        // program ch1..3, leave ch0 disabled
        write_reg(2'd1, 1'b0, 32'h0040_0001);
        write_reg(2'd1, 1'b1, 32'h0000_FFF0);
        write_reg(2'd2, 1'b0, 32'h0080_0051);
        write_reg(2'd2, 1'b1, 32'h0000_FF0E);   // bits 3:1 set: R10
        write_reg(2'd3, 1'b0, 32'h0080_0001);
        write_reg(2'd3, 1'b1, 32'h00FF_FFF0);
        write_reg(2'd0, 1'b1, 32'h000F_FFF0);

        // R2 boot mode overrides other channels
        probe(32'h0040_1234, 3'd1);
        check("R2 boot over ch1", cs_sel, 1);
        probe(32'hFFFF_FFFF, 3'd7);
        check("R2 boot any addr", cs_sel, 1);

        // enable ch0 with bits 3:1 set (R10), ENABLE transition
        write_reg(2'd0, 1'b0, 32'h0000_000F);

        for (int i = 0; i < NV; i++) begin
            probe(VEC[i][37:6], VEC[i][5:3]);
            check($sformatf("R4/R5/R6/R7/R10 vector %0d", i), cs_sel, VEC[i][2:0]);
        end

        // R3 disable ch1: its window falls to ch3
        write_reg(2'd1, 1'b0, 32'h0040_0000);
        probe(32'h0040_1234, 3'd1);
        check("R3 disabled ch1", cs_sel, 4);

        // R8 write timing: re-enable ch1, visible the cycle after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'd1; wr_is_mask = 1'b0; wr_data = 32'h0040_0001;
        #(CLK_PERIOD/4);
        check("R8 before edge", cs_sel, 4);
        @(negedge clk);
        wr_en = 1'b0;
        #(CLK_PERIOD/4);
        check("R8 after edge", cs_sel, 2);

        // R8 mask write narrows ch3 so 0x0010_0000 misses
        write_reg(2'd3, 1'b1, 32'h000F_FFF0);
        probe(32'h0010_0000, 3'd2);
        check("R8 mask rewrite", cs_sel, 0);

        // R9 registered copy
        @(negedge clk);
        acc_addr = 32'h0040_0010; acc_fc = 3'd0; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'hFFFF_0000;
        check("R9 captured sel", cs_sel_q, 2);
        check("R9 vld high", cs_sel_q_vld, 1);
        @(negedge clk);
        check("R9 hold sel", cs_sel_q, 2);
        check("R9 vld low", cs_sel_q_vld, 0);

        // R10 base bits 3:1 cleared on ch0 change nothing
        write_reg(2'd0, 1'b0, 32'h0000_0001);
        probe(32'h0000_1000, 3'd0);
        check("R10 ch0 still hits", cs_sel, 1);

        // DISABLE transition back to boot
        write_reg(2'd0, 1'b0, 32'h0000_0000);
        probe(32'hFFFF_0000, 3'd4);
        check("R2 boot again", cs_sel, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule